// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 64K words by 16 bits, split into two byte lanes. The host offers one request at a time over a valid/ready handshake: a read or write flag, a word address, write data and a per-lane byte mask. The controller turns each request into a sequence of active-low memory strobes. Each phase lasts a number of clock cycles computed at elaboration from the memory's nanosecond limits and the clock period. A read returns its word together with a one-cycle valid strobe.

Every timing value is converted to cycles by rounding up, with a floor of one cycle. At the default 8 ns clock this gives a 2-cycle read access, a 1-cycle write-enable pulse and 1 recovery cycle. The data bus is modelled as separate output, output-enable and input signals. The controller drives the bus only while write enable is low and for the recovery cycles after it rises. Output enable stays high for the whole of a write. When a write is accepted in the first idle cycle after a read, the controller inserts a turnaround gap so that the memory's output drivers can release the bus first.

Top module: `asr_ctrl`

## Requirements
- R1: While reset is held and directly after it, req_ready is 1, rsp_valid is 0, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_be_n is all ones and mem_dq_oe is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the access sequence has finished. mem_addr holds the request address for as long as mem_cs_n is low.
- R3: A read holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for ceil(max(read cycle, address access)/clock period) cycles (2 at the defaults), starting the cycle after acceptance.
- R4: While mem_cs_n is low, mem_be_n[i] is the inverse of req_mask[i]. Bit 1 is the upper lane (data 15..8) and bit 0 is the lower lane (data 7..0), so a mask of 00 leaves both byte enables high. When mem_cs_n is high, mem_be_n is all ones.
- R5: mem_dq_in is registered on the edge that ends the read phase. rsp_valid is then 1 for exactly one cycle. Lanes whose byte enable was high return whatever the idle bus carries (0 in the bench).
- R6: A write holds mem_cs_n=0, mem_we_n=0 and mem_oe_n=1 for ceil(max(write pulse, address-to-end, data setup)/period) cycles (1 at the defaults). mem_we_n is never low while mem_oe_n is low.
- R7: mem_dq_oe is 1 only during the write-enable-low cycles and the recovery cycles after them, and mem_dq_out then carries the write data. A lane whose mask bit is 0 is left unchanged in memory.
- R8: After write enable rises, a recovery phase with all strobes high lasts max(1, ceil(write cycle/period) - pulse cycles) cycles. Only after it does req_ready return to 1.
- R9: A write accepted in the first idle cycle after a read completes first spends ceil(bus release time/period) cycles (1 at the defaults) with all strobes high and the bus undriven, and only then lowers mem_we_n.
- R10: Outside read and write-enable-low phases mem_cs_n is high, and when idle the bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Lane enables, bit 1 upper byte, bit 0 lower byte |
| rsp_data | output | DW | Read data |
| rsp_valid | output | 1 | One-cycle strobe marking rsp_data |
| mem_addr | output | AW | Memory address lines |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DW/8 | Byte enables, active low, bit 1 upper |
| mem_dq_out | output | DW | Data toward memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DW | Data from memory |

## Verification
The bench goes after partial-lane reads and writes and a mask of 00. If the lane mapping were swapped or inverted, it would return or change the wrong byte, and a mask of 00 would alter stored data. A write issued immediately after a read exercises the turnaround: without the gap, write enable would fall, and the bus would be driven, while the memory could still be releasing it. Phase lengths are compared every cycle against counts the bench derives on its own from the nanosecond figures, so a strobe held one cycle short or long, or a missing recovery cycle, shows up at once.

// File: rtl/asr_pkg.sv
package asr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TURN = 3'd1,
      ST_READ = 3'd2,
      ST_WLOW = 3'd3,
      ST_WREC = 3'd4
   } asr_state_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // nanoseconds to cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/asr_cnt.sv
module asr_cnt #(
   parameter int unsigned CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/asr_lane_map.sv
module asr_lane_map #(
   parameter int unsigned LANES = 2
) (
   input  logic             en,
   input  logic [LANES-1:0] mask,
   output logic [LANES-1:0] be_n
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be_n[g] = ~(en & mask[g]);
   end
endmodule

// File: rtl/asr_req_hold.sv
module asr_req_hold #(
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 16,
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    data_i,
   input  logic [LANES-1:0] mask_i,
   output logic [AW-1:0]    addr_o,
   output logic [DW-1:0]    data_o,
   output logic [LANES-1:0] mask_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o <= '0;
         data_o <= '0;
         mask_o <= '0;
      end else if (take) begin
         addr_o <= addr_i;
         data_o <= data_i;
         mask_o <= mask_i;
      end
   end
endmodule

// File: rtl/asr_ctrl.sv
module asr_ctrl
   import asr_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 16,
   parameter int unsigned CLK_NS    = 8,
   parameter int unsigned T_RC_NS   = 10,
   parameter int unsigned T_AA_NS   = 10,
   parameter int unsigned T_WC_NS   = 10,
   parameter int unsigned T_WP_NS   = 7,
   parameter int unsigned T_AW_NS   = 7,
   parameter int unsigned T_DW_NS   = 5,
   parameter int unsigned T_HZ_NS   = 5,
   localparam int unsigned LANES    = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [LANES-1:0] req_mask,
   output logic [DW-1:0]    rsp_data,
   output logic             rsp_valid,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_cs_n,
   output logic             mem_we_n,
   output logic             mem_oe_n,
   output logic [LANES-1:0] mem_be_n,
   output logic [DW-1:0]    mem_dq_out,
   output logic             mem_dq_oe,
   input  logic [DW-1:0]    mem_dq_in
);
   localparam int unsigned RD_CYC  = ns_to_cyc(imax(T_RC_NS, T_AA_NS), CLK_NS);
   localparam int unsigned WP_CYC  = ns_to_cyc(imax(T_WP_NS, imax(T_AW_NS, T_DW_NS)), CLK_NS);
   localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
   localparam int unsigned TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int unsigned MAXC    = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
   localparam int unsigned CW      = (MAXC < 2) ? 1 : $clog2(MAXC);

   if (DW % 8 != 0 || DW == 0) begin : g_bad_dw
      $error("asr_ctrl: DW must be a non-zero multiple of 8");
   end
   if (CLK_NS == 0) begin : g_bad_clk
      $error("asr_ctrl: CLK_NS must be non-zero");
   end
   if (AW == 0) begin : g_bad_aw
      $error("asr_ctrl: AW must be non-zero");
   end

   asr_state_e       state_q, state_d;
   logic             cnt_load, cnt_last;
   logic [CW-1:0]    cnt_val;
   logic             take, rd_done, turn_q;
   logic [LANES-1:0] hold_mask;
   logic             lanes_on;

   assign take    = req_valid && (state_q == ST_IDLE);
   assign rd_done = (state_q == ST_READ) && cnt_last;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            cnt_load = 1'b1;
            if (!req_write) begin
               state_d = ST_READ;
               cnt_val = CW'(RD_CYC - 1);
            end else if (turn_q) begin
               state_d = ST_TURN;
               cnt_val = CW'(TA_CYC - 1);
            end else begin
               state_d = ST_WLOW;
               cnt_val = CW'(WP_CYC - 1);
            end
         end
         ST_TURN: if (cnt_last) begin
            state_d  = ST_WLOW;
            cnt_load = 1'b1;
            cnt_val  = CW'(WP_CYC - 1);
         end
         ST_READ: if (cnt_last) state_d = ST_IDLE;
         ST_WLOW: if (cnt_last) begin
            state_d  = ST_WREC;
            cnt_load = 1'b1;
            cnt_val  = CW'(REC_CYC - 1);
         end
         ST_WREC: if (cnt_last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         turn_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         state_q   <= state_d;
         turn_q    <= rd_done;
         rsp_valid <= rd_done;
         if (rd_done) rsp_data <= mem_dq_in;
      end
   end

   asr_cnt #(.CW(CW)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .last     (cnt_last)
   );

   asr_req_hold #(.AW(AW), .DW(DW), .LANES(LANES)) hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .addr_i (req_addr),
      .data_i (req_wdata),
      .mask_i (req_mask),
      .addr_o (mem_addr),
      .data_o (mem_dq_out),
      .mask_o (hold_mask)
   );

   assign lanes_on = (state_q == ST_READ) || (state_q == ST_WLOW);

   asr_lane_map #(.LANES(LANES)) lane_i (
      .en   (lanes_on),
      .mask (hold_mask),
      .be_n (mem_be_n)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign mem_cs_n  = ~lanes_on;
   assign mem_oe_n  = (state_q != ST_READ);
   assign mem_we_n  = (state_q != ST_WLOW);
   assign mem_dq_oe = (state_q == ST_WLOW) || (state_q == ST_WREC);
endmodule

// File: rtl/asr_ctrl_chk.sv
module asr_ctrl_chk #(
   parameter int unsigned AW    = 16,
   parameter int unsigned LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [AW-1:0]    mem_addr,
   input logic             mem_cs_n,
   input logic             mem_we_n,
   input logic             mem_oe_n,
   input logic [LANES-1:0] mem_be_n,
   input logic             mem_dq_oe
);
   AST_WE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_oe_n); // R6
   AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> !mem_cs_n); // R6
   AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_dq_oe); // R7
   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R7
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (mem_cs_n && !mem_dq_oe)); // R10
   AST_BE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n |-> (&mem_be_n)); // R4
   AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_oe_n) |=> (mem_we_n && !mem_dq_oe)); // R9
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R2
endmodule

bind asr_ctrl asr_ctrl_chk #(.AW(AW), .LANES(LANES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_be_n  (mem_be_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/asr_ctrl_tb_top.sv
`timescale 1ns/1ps
module asr_ctrl_tb_top;
   localparam int PER = 8;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int M_RD  = cyc((10 > 10) ? 10 : 10);
   localparam int M_WP  = cyc(7);
   localparam int M_WC  = cyc(10);
   localparam int M_REC = (M_WC - M_WP > 1) ? (M_WC - M_WP) : 1;
   localparam int M_TA  = cyc(5);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_data, mem_addr, mem_dq_out;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] sram_q = '0;

   always #(PER/2) clk = ~clk;

   asr_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(sram_q)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
      end
   endtask

   // behavioural memory and shadow
   logic [15:0] mem_arr [int];
   logic [15:0] shadow  [int];
   logic [15:0] exp_q [$];

   function automatic logic [15:0] rd_arr(input int a);
      return mem_arr.exists(a) ? mem_arr[a] : 16'h0000;
   endfunction
   function automatic logic [15:0] rd_shadow(input int a);
      return shadow.exists(a) ? shadow[a] : 16'h0000;
   endfunction

   // reference model: phase 0 idle, 1 turn, 2 read, 3 we low, 4 recovery
   int          m_phase = 0, m_left = 0;
   logic        m_turn = 1'b0, m_rvalid = 1'b0;
   logic [15:0] m_addr = '0, m_data = '0;
   logic [1:0]  m_mask = '0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_phase = 0; m_turn = 1'b0; m_rvalid = 1'b0;
      end else begin
         logic nt;
         nt = 1'b0;
         m_rvalid = 1'b0;
         case (m_phase)
            0: if (req_valid) begin
               m_addr = req_addr; m_data = req_wdata; m_mask = req_mask;
               if (!req_write) begin m_phase = 2; m_left = M_RD; end
               else if (m_turn) begin m_phase = 1; m_left = M_TA; end
               else begin m_phase = 3; m_left = M_WP; end
            end
            1: if (m_left == 1) begin m_phase = 3; m_left = M_WP; end else m_left--;
            2: if (m_left == 1) begin m_phase = 0; m_rvalid = 1'b1; nt = 1'b1; end else m_left--;
            3: if (m_left == 1) begin m_phase = 4; m_left = M_REC; end else m_left--;
            4: if (m_left == 1) m_phase = 0; else m_left--;
            default: m_phase = 0;
         endcase
         m_turn = nt;
      end
   end

   always @(negedge clk) begin
      // memory behaviour
      if (!mem_cs_n && !mem_we_n) begin
         logic [15:0] w;
         w = rd_arr(int'(mem_addr));
         if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
         if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
         mem_arr[int'(mem_addr)] = w;
      end
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
         logic [15:0] r;
         r = rd_arr(int'(mem_addr));
         sram_q = { mem_be_n[1] ? 8'h00 : r[15:8], mem_be_n[0] ? 8'h00 : r[7:0] };
      end else
         sram_q = 16'h0000;

      if (rst_n) begin
         string ptag;
         logic e_cs, e_we, e_oe, e_drv;
         logic [1:0] e_be;
         case (m_phase)
            1: ptag = "R9";
            2: ptag = "R3";
            3: ptag = "R6";
            4: ptag = "R8";
            default: ptag = "R10";
         endcase
         e_cs  = !(m_phase == 2 || m_phase == 3);
         e_we  = (m_phase != 3);
         e_oe  = (m_phase != 2);
         e_drv = (m_phase == 3 || m_phase == 4);
         e_be  = e_cs ? 2'b11 : ~m_mask;
         chk({ptag, " cs_n"}, 32'(mem_cs_n), 32'(e_cs));
         chk({ptag, " we_n"}, 32'(mem_we_n), 32'(e_we));
         chk({ptag, " oe_n"}, 32'(mem_oe_n), 32'(e_oe));
         chk("R4 be_n", 32'(mem_be_n), 32'(e_be));
         chk("R7 dq_oe", 32'(mem_dq_oe), 32'(e_drv));
         if (e_drv) chk("R7 dq_out", 32'(mem_dq_out), 32'(m_data));
         chk("R2 ready", 32'(req_ready), 32'(m_phase == 0));
         if (m_phase != 0) chk("R2 addr", 32'(mem_addr), 32'(m_addr));
         chk("R5 rsp_valid", 32'(rsp_valid), 32'(m_rvalid));
         if (rsp_valid) begin
            if (exp_q.size() == 0) chk("R5 unexpected response", 32'(rsp_data), 32'hDEAD);
            else chk("R5 rsp_data", 32'(rsp_data), 32'(exp_q.pop_front()));
         end
      end
   end

   task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      if (wr) begin
         logic [15:0] s;
         s = rd_shadow(int'(a));
         if (m[1]) s[15:8] = d[15:8];
         if (m[0]) s[7:0]  = d[7:0];
         shadow[int'(a)] = s;
      end else begin
         logic [15:0] s;
         s = rd_shadow(int'(a));
         exp_q.push_back({ m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00 });
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      while (cycles < 100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cycles);
      finish_run();
   end

   initial begin
      int unsigned lcg;
      repeat (3) @(negedge clk);
      // R1: reset values held
      chk("R1 ready", 32'(req_ready), 32'd1);
      chk("R1 strobes", 32'({mem_cs_n, mem_we_n, mem_oe_n, mem_be_n}), 32'h1F);
      chk("R1 dq_oe/rsp_valid", 32'({mem_dq_oe, rsp_valid}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({req_ready, mem_cs_n, mem_dq_oe}), 32'b110);

      issue(1'b1, 16'h0005, 16'h1234, 2'b11);   // full write
      issue(1'b0, 16'h0005, 16'h0000, 2'b11);   // full read
      issue(1'b0, 16'h0005, 16'h0000, 2'b01);   // R4 lower lane only
      issue(1'b0, 16'h0005, 16'h0000, 2'b10);   // R4 upper lane only
      issue(1'b1, 16'h0005, 16'hFFAB, 2'b01);   // R7 lower-lane write, directly after read (R9)
      issue(1'b0, 16'h0005, 16'h0000, 2'b11);
      issue(1'b1, 16'h0005, 16'h9999, 2'b00);   // R4 mask 00: memory untouched
      issue(1'b0, 16'h0005, 16'h0000, 2'b11);
      issue(1'b0, 16'h0005, 16'h0000, 2'b00);   // R4 mask 00 read returns idle bus
      issue(1'b1, 16'hFFFF, 16'hA55A, 2'b10);   // top address, upper lane
      repeat (3) @(negedge clk);
      issue(1'b0, 16'hFFFF, 16'h0000, 2'b11);

      lcg = 32'h1ACE;
      for (int i = 0; i < 40; i++) begin
         lcg = lcg * 1103515245 + 12345;
         issue(lcg[20], {12'h0, lcg[11:8]}, lcg[31:16], lcg[23:22]);
         if (lcg[5]) repeat (int'(lcg[7:6])) @(negedge clk);
      end

      repeat (10) @(negedge clk);
      chk("R5 all responses returned", 32'(exp_q.size()), 32'd0);
      finish_run();
   end
endmodule